// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory read or write burst. A start strobe loads a column address together with a burst length code and an ordering mode. From the next cycle on, the block presents one beat per cycle in which the advance enable is high. Each beat carries its column address, a valid flag and a flag that marks the final beat of the burst.

A burst always stays inside the naturally aligned block of its own length. Only the low one to four column bits move, either counting upward with wrap-around or formed as the start offset XOR the beat number. A burst ends after its final beat has been advanced, when a stop strobe arrives, or when a new start replaces it. Column commands may follow each other on consecutive clocks. The controller that uses this block supplies the command timing. The block only sequences addresses.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `beat_vld` and `beat_last` are 0. No burst is active until a start.
- R2: `blen_code` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. `beat_last` is 1 exactly on the beat whose index equals the length minus one.
- R3: With `order` = 0 (sequential), the low log2(length) bits of beat i are (start offset + i) modulo the length. For example, offset 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R4: With `order` = 1 (interleaved), the low bits of beat i are the start offset XOR i. For example, offset 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: The column bits above the burst field equal those of the start address on every beat of the burst.
- R6: A start makes `beat_vld` 1 in the next cycle, with `col_out` equal to `start_col` and the beat index back at 0. This holds even during an active burst, and a start wins over a stop in the same cycle.
- R7: A stop without a start drops `beat_vld` in the next cycle. When the block is idle, a stop leaves it idle.
- R8: While a burst is active and `adv` is 0 (with no start or stop), `col_out`, `beat_vld` and `beat_last` hold their values.
- R9: After the final beat is advanced, `beat_vld` is 0 in the next cycle. Starts on consecutive clocks each produce their first beat one cycle later.
- R10: Length code and order are captured at the start. Changing `blen_code` or `order` during a burst has no effect on its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new burst |
| start_col | input | 10 | Starting column address |
| blen_code | input | 2 | Burst length code (2,4,8,16) |
| order | input | 1 | 0 sequential, 1 interleaved |
| adv | input | 1 | Advance to the next beat |
| stop | input | 1 | Terminate the current burst |
| col_out | output | 10 | Column address of the current beat |
| beat_vld | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The hardest situation to reach is the interaction of the interruptions. Cases include a start that lands on the final beat, a start together with a stop, and inputs for length and order that change in the middle of a burst. A bench model tracks all of these cycle by cycle. Directed sequences cover the two documented example orders, a run of starts on consecutive clocks and a stop while idle. Random stimulus from a fixed seed then drives start, stop and advance at mixed rates, while length, order and address change every cycle. This forces many bursts to be cut short at arbitrary beats of all four lengths.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/bcs_len_decode.sv
// Turns a length code into the mask of the column bits that move.
module bcs_len_decode #(
  parameter int IDX_W  = 4,
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  mask
);
  for (genvar i = 0; i < IDX_W; i++) begin : g_bit
    assign mask[i] = (CODE_W'(i) <= code);
  end
endmodule

// File: rtl/bcs_offset.sv
// Low-bit generator: sequential wrap or XOR ordering.
module bcs_offset #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] base_off,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] mask,
  input  bcs_pkg::order_e  order,
  output logic [IDX_W-1:0] low
);
  logic [IDX_W-1:0] seq_low;
  logic [IDX_W-1:0] xor_low;

  assign seq_low = (base_off + idx) & mask;
  assign xor_low = (base_off ^ idx) & mask;

  always_comb begin
    if (order == bcs_pkg::ORD_XOR) low = xor_low;
    else                           low = seq_low;
  end
endmodule

// File: rtl/bcs_burst_ctl.sv
// Beat index and burst activity.
module bcs_burst_ctl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             adv,
  input  logic [IDX_W-1:0] last_idx,
  output logic             act_n,
  output logic [IDX_W-1:0] idx_n
);
  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    act_n = act_q;
    idx_n = idx_q;
    if (start) begin
      act_n = 1'b1;
      idx_n = '0;
    end else if (stop) begin
      act_n = 1'b0;
      idx_n = '0;
    end else if (act_q && adv) begin
      if (idx_q == last_idx) begin
        act_n = 1'b0;
        idx_n = '0;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_n;
      idx_q <= idx_n;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       blen_code,
  input  logic             order,
  input  logic             adv,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             beat_vld,
  output logic             beat_last
);
  localparam int IDX_W  = MAX_LOG2;
  localparam int CODE_W = 2;
  localparam int HI_W   = COL_W - IDX_W;

  logic [COL_W-1:0]  base_q, base_n;
  logic [CODE_W-1:0] code_q, code_n;
  bcs_pkg::order_e   ord_q, ord_n;
  logic [IDX_W-1:0]  mask_q, mask_n;
  logic              act_n;
  logic [IDX_W-1:0]  idx_n;
  logic [IDX_W-1:0]  low_n;
  logic [COL_W-1:0]  wide_mask;
  logic [COL_W-1:0]  col_n;

  assign base_n = start ? start_col : base_q;
  assign code_n = start ? blen_code : code_q;
  assign ord_n  = start ? bcs_pkg::order_e'(order) : ord_q;

  bcs_len_decode #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_dec_cur (
    .code (code_q),
    .mask (mask_q)
  );

  bcs_len_decode #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_dec_nxt (
    .code (code_n),
    .mask (mask_n)
  );

  bcs_burst_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (stop),
    .adv      (adv),
    .last_idx (mask_q),
    .act_n    (act_n),
    .idx_n    (idx_n)
  );

  bcs_offset #(.IDX_W(IDX_W)) u_off (
    .base_off (base_n[IDX_W-1:0]),
    .idx      (idx_n),
    .mask     (mask_n),
    .order    (ord_n),
    .low      (low_n)
  );

  assign wide_mask = {{HI_W{1'b0}}, mask_n};
  assign col_n     = (base_n & ~wide_mask) | {{HI_W{1'b0}}, low_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      code_q    <= '0;
      ord_q     <= bcs_pkg::ORD_SEQ;
      col_out   <= '0;
      beat_vld  <= 1'b0;
      beat_last <= 1'b0;
    end else begin
      base_q    <= base_n;
      code_q    <= code_n;
      ord_q     <= ord_n;
      col_out   <= col_n;
      beat_vld  <= act_n;
      beat_last <= act_n && (idx_n == mask_n);
    end
  end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 10,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             adv,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             beat_vld,
  input logic             beat_last
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!beat_vld && !beat_last));

  a_r2_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_vld);

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (beat_vld && adv && !beat_last && !start && !stop) |=>
      (beat_vld && col_out[COL_W-1:IDX_W] == $past(col_out[COL_W-1:IDX_W])));

  a_r6_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (beat_vld && col_out == $past(start_col)));

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !beat_vld);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_vld && !adv && !start && !stop) |=>
      (beat_vld && $stable(col_out) && $stable(beat_last)));

  a_r9_drop_after_last: assert property (@(posedge clk) disable iff (rst)
    (beat_vld && beat_last && adv && !start && !stop) |=> !beat_vld);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .IDX_W(MAX_LOG2)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_col (start_col),
  .adv       (adv),
  .stop      (stop),
  .col_out   (col_out),
  .beat_vld  (beat_vld),
  .beat_last (beat_last)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [9:0] start_col = '0;
  logic [1:0] blen_code = '0;
  logic       order = 1'b0;
  logic       adv = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] col_out;
  logic       beat_vld;
  logic       beat_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit       m_act = 0;
  int       m_idx = 0;
  bit [9:0] m_base = 0;
  int       m_code = 0;
  bit       m_ord = 0;

  always #10 clk = ~clk;

  burst_col_seq u0 (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .blen_code(blen_code), .order(order), .adv(adv), .stop(stop),
    .col_out(col_out), .beat_vld(beat_vld), .beat_last(beat_last)
  );

  function automatic int blen(int k);
    return 2 << k;
  endfunction

  function automatic bit [9:0] exp_col(bit [9:0] b, int k, bit md, int i);
    int n   = blen(k);
    int off = int'(b) % n;
    int low = md ? (off ^ i) : ((off + i) % n);
    return 10'(int'(b) - off + low);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit [9:0] c, input bit [1:0] bl, input bit md,
                      input bit sp, input bit av, input string tag);
    start = s; start_col = c; blen_code = bl; order = md; stop = sp; adv = av;
    @(posedge clk);
    if (s) begin
      m_act = 1; m_idx = 0; m_base = c; m_code = bl; m_ord = md;
    end else if (sp) begin
      m_act = 0;
    end else if (m_act && av) begin
      if (m_idx == blen(m_code) - 1) m_act = 0;
      else m_idx++;
    end
    @(negedge clk);
    check(tag, beat_vld, m_act, "beat_vld");
    if (m_act) begin
      check(tag, col_out, exp_col(m_base, m_code, m_ord, m_idx), "col_out");
      check("R5", col_out[9:4], m_base[9:4], "upper col bits");
      check("R2", beat_last, (m_idx == blen(m_code) - 1), "beat_last");
    end
  endtask

  task automatic idle_step(input bit av, input string tag);
    step(0, start_col, blen_code, order, 0, av, tag);
  endtask

  int seq_ex[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
  int xor_ex[8] = '{5, 4, 7, 6, 1, 0, 3, 2};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", beat_vld, 0, "beat_vld after reset");
    check("R1", beat_last, 0, "beat_last after reset");
    step(0, 10'h000, 2'd0, 0, 1, 1, "R7");   // stop while idle

    // R3 documented example, length 8
    step(1, 10'h3C5, 2'd2, 0, 0, 1, "R6");
    for (int k = 0; k < 8; k++) begin
      check("R3", col_out[2:0], seq_ex[k], "seq low bits");
      idle_step(1, "R3");
    end
    check("R9", beat_vld, 0, "valid after final beat");

    // R4 documented example, length 8
    step(1, 10'h105, 2'd2, 1, 0, 1, "R6");
    for (int k = 0; k < 8; k++) begin
      check("R4", col_out[2:0], xor_ex[k], "xor low bits");
      idle_step(1, "R4");
    end

    // length 16 interleaved and length 2 sequential
    step(1, 10'h2AB, 2'd3, 1, 0, 1, "R6");
    for (int k = 0; k < 16; k++) idle_step(1, "R4");
    step(1, 10'h0F1, 2'd0, 0, 0, 1, "R6");
    for (int k = 0; k < 3; k++) idle_step(1, "R3");

    // R8 hold with adv low
    step(1, 10'h033, 2'd1, 0, 0, 0, "R6");
    for (int k = 0; k < 4; k++) idle_step(0, "R8");
    idle_step(1, "R3");

    // R7 stop mid-burst
    idle_step(1, "R3");
    step(0, 10'h0, 2'd0, 0, 1, 1, "R7");
    idle_step(1, "R7");

    // R6 restart mid-burst, and start beating a stop
    step(1, 10'h1F7, 2'd3, 0, 0, 1, "R6");
    idle_step(1, "R3");
    step(1, 10'h08A, 2'd2, 1, 0, 1, "R6");
    step(1, 10'h0C9, 2'd1, 0, 1, 1, "R6");
    // back-to-back starts every clock
    for (int k = 0; k < 6; k++) step(1, 10'(k * 37 + 3), 2'(k), k[0], 0, 1, "R9");

    // R10: inputs change mid-burst without start
    step(1, 10'h256, 2'd2, 0, 0, 1, "R6");
    for (int k = 0; k < 8; k++) step(0, 10'h3FF, 2'(k), ~k[0], 0, 1, "R10");

    // constrained random
    void'($urandom(32'd12345));
    for (int n = 0; n < 4000; n++) begin
      bit s   = ($urandom % 8) == 0;
      bit sp  = ($urandom % 16) == 0;
      bit av  = ($urandom % 4) != 0;
      bit md  = 1'($urandom);
      bit [1:0] bl = 2'($urandom);
      bit [9:0] c  = 10'($urandom);
      string tag;
      if (s) tag = "R6";
      else if (sp) tag = "R7";
      else if (!av) tag = "R8";
      else if (m_act && m_ord) tag = "R4";
      else tag = "R3";
      step(s, c, bl, md, sp, av, tag);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule